// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed station-management master that runs Clause 22 read and write frames on a two-wire management bus to external PHYs. Software first programs a control word that enables the block and sets a clock divider. It then writes one command word. That word holds a start flag, a direction flag, a 5-bit PHY address, a 5-bit register address and 16 data bits. The block shifts out the complete frame on MDC/MDIO. When the frame ends, the start flag clears itself and the command word holds the result.

On a read, the master releases the data line for the turnaround and data fields. It samples the PHY on rising MDC edges. It returns the 16 data bits together with a flag that shows whether the PHY pulled the line low in the second turnaround bit. Every acknowledged read of the PHY status register (register 1) copies bit 2 of the returned data into the link bitmap, at the bit position equal to the PHY address. Software polls the idle flag or the start flag to learn when a frame has ended.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle set, enable clear, divider 0), the command word and link bitmap read 0, and `mdc` and `mdio_oe` are low.
- R2: Control word (select 0): bit 30 is the enable and bits DIV_W-1:0 are the divider; both read back as written. Bit 31 reads 1 only when no frame is pending or running.
- R3: During a frame `mdc` toggles every divider+1 clock cycles, so one MDC period is 2*(divider+1) cycles. Outside a frame `mdc` stays low.
- R4: A write frame drives 64 bits MSB-first with `mdio_oe` high throughout: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits.
- R5: A read frame drives 32 ones, start 01, opcode 10 and both addresses (46 bits). It then holds `mdio_oe` low for the 2 turnaround bits and 16 data bits.
- R6: `mdio_o` changes only with a falling MDC edge (never when `mdc` rises). `mdio_i` is sampled with the rising edge.
- R7: Command word (select 1) layout: bit 31 start, bit 30 write(1)/read(0), bit 29 acknowledge, bits 25:21 register, bits 20:16 PHY, bits 15:0 data. Setting bit 31 starts one frame of exactly 64 MDC rising edges, and bit 31 clears itself when the frame ends.
- R8: After a read, bits 15:0 hold the 16 bits sampled from the PHY. Bit 29 is set only if `mdio_i` was low at the second turnaround bit. After a write, bit 29 reads 0.
- R9: Writes to the command word while bit 31 is set are ignored; the running frame and the stored fields are unchanged.
- R10: Link bitmap (select 2, read-only) bit N takes data bit 2 after an acknowledged read of register 1 from PHY N. Reads of other registers and unacknowledged reads leave it unchanged.
- R11: Writing the start bit while the enable is clear is ignored: bit 31 stays 0, the idle bit stays 1 and `mdc` does not toggle.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 control, 1 command, 2 link (ignored) |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as reg_sel |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that the divider is not reprogrammed while a frame runs. They also assume that register writes arrive as single-cycle strobes. The PHY model in the stimulus changes `mdio_i` only on falling MDC edges. It drives the line high whenever it is not answering a read. This keeps the input steady at every rising-edge sample. Divider changes are made only between frames, after the bench has seen the start bit clear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int TA_IDX    = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int DATA_IDX  = TA_IDX + 2;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int LINK_W    = 1 << PHY_AW;

    localparam logic [1:0] ST_CODE = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_WR   = 2'b10;
    localparam logic [1:0] TA_RD   = 2'b11;

    localparam logic [REG_AW-1:0] STATUS_REG = REG_AW'(1);
    localparam int LINK_BIT = 2;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_LINK = 2'd2;

    localparam int CT_IDLE  = 31;
    localparam int CT_EN    = 30;
    localparam int CM_GO    = 31;
    localparam int CM_WR    = 30;
    localparam int CM_ACK   = 29;
    localparam int CM_REG_L = 21;
    localparam int CM_PHY_L = 16;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_s;

    div_s q, d;
    logic tick;

    assign tick = run && (q.cnt == div);
    assign rise = tick && !q.mdc;
    assign fall = tick && q.mdc;
    assign mdc  = q.mdc;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_TA   = CNT_W'(TA_IDX);
    localparam logic [CNT_W-1:0] CNT_TA2  = CNT_W'(TA_IDX + 1);
    localparam logic [CNT_W-1:0] CNT_DAT  = CNT_W'(DATA_IDX);

    typedef struct packed {
        logic                 busy;
        logic                 rd;
        logic [FRAME_LEN-1:0] sh;
        logic [CNT_W-1:0]     cnt;
        logic                 oe;
        logic                 dout;
        logic [DATA_W-1:0]    rdat;
        logic                 ack;
        logic                 done;
    } eng_s;

    eng_s q, d;
    logic [FRAME_LEN-1:0] frame;
    logic [CNT_W-1:0]     idx;

    assign frame = {{PRE_LEN{1'b1}}, ST_CODE, is_read ? OP_RD : OP_WR,
                    phy_addr, reg_addr, is_read ? TA_RD : TA_WR,
                    is_read ? {DATA_W{1'b0}} : wdata};
    assign idx = q.cnt - CNT_W'(1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.rd   = is_read;
            d.dout = frame[FRAME_LEN-1];
            d.sh   = frame << 1;
            d.cnt  = CNT_W'(1);
            d.oe   = 1'b1;
            d.ack  = 1'b0;
        end else if (q.busy) begin
            if (mdc_rise && q.rd) begin
                if (idx == CNT_TA2)
                    d.ack = !mdio_i;
                else if (idx >= CNT_DAT)
                    d.rdat = {q.rdat[DATA_W-2:0], mdio_i};
            end
            if (mdc_fall) begin
                if (q.cnt == CNT_LAST) begin
                    d.busy = 1'b0;
                    d.oe   = 1'b0;
                    d.dout = 1'b1;
                    d.done = 1'b1;
                end else begin
                    d.dout = q.sh[FRAME_LEN-1];
                    d.sh   = q.sh << 1;
                    d.oe   = !(q.rd && (q.cnt >= CNT_TA));
                    d.cnt  = q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign mdio_o  = q.dout;
    assign mdio_oe = q.oe;
    assign rdata   = q.rdat;
    assign ack     = q.ack;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  rd_sel,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic              en;
        logic [DIV_W-1:0]  div;
        logic              go;
        logic              wr;
        logic [REG_AW-1:0] rega;
        logic [PHY_AW-1:0] phya;
        logic [DATA_W-1:0] data;
        logic              ack;
        logic [LINK_W-1:0] link;
    } regs_s;

    regs_s r_q, r_d;

    logic              eng_busy, eng_done, eng_ack;
    logic [DATA_W-1:0] eng_rdata;
    logic              clk_rise, clk_fall, start, go_q, idle;
    logic              unused_wbits;

    assign go_q         = r_q.go;
    assign start        = go_q && !eng_busy && !eng_done;
    assign idle         = !go_q && !eng_busy;
    assign unused_wbits = ^reg_wdata;

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .div  (r_q.div),
        .mdc  (mdc),
        .rise (clk_rise),
        .fall (clk_fall)
    );

    mdio_frame_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_read (!r_q.wr),
        .phy_addr(r_q.phya),
        .reg_addr(r_q.rega),
        .wdata   (r_q.data),
        .mdc_rise(clk_rise),
        .mdc_fall(clk_fall),
        .mdio_i  (mdio_i),
        .busy    (eng_busy),
        .done    (eng_done),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rdata   (eng_rdata),
        .ack     (eng_ack)
    );

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            if (reg_sel == SEL_CTRL) begin
                r_d.en  = reg_wdata[CT_EN];
                r_d.div = reg_wdata[DIV_W-1:0];
            end else if (reg_sel == SEL_CMD && !r_q.go) begin
                r_d.go   = reg_wdata[CM_GO] && r_q.en;
                r_d.wr   = reg_wdata[CM_WR];
                r_d.rega = reg_wdata[CM_REG_L +: REG_AW];
                r_d.phya = reg_wdata[CM_PHY_L +: PHY_AW];
                r_d.data = reg_wdata[DATA_W-1:0];
                r_d.ack  = 1'b0;
            end
        end
        if (eng_done) begin
            r_d.go = 1'b0;
            if (r_q.wr) begin
                r_d.ack = 1'b0;
            end else begin
                r_d.data = eng_rdata;
                r_d.ack  = eng_ack;
                if (eng_ack && r_q.rega == STATUS_REG)
                    r_d.link[r_q.phya] = eng_rdata[LINK_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (rd_sel)
            SEL_CTRL: begin
                reg_rdata[CT_IDLE]   = idle;
                reg_rdata[CT_EN]     = r_q.en;
                reg_rdata[DIV_W-1:0] = r_q.div;
            end
            SEL_CMD: begin
                reg_rdata[CM_GO]              = r_q.go;
                reg_rdata[CM_WR]              = r_q.wr;
                reg_rdata[CM_ACK]             = r_q.ack;
                reg_rdata[CM_REG_L +: REG_AW] = r_q.rega;
                reg_rdata[CM_PHY_L +: PHY_AW] = r_q.phya;
                reg_rdata[DATA_W-1:0]         = r_q.data;
            end
            SEL_LINK: reg_rdata[LINK_W-1:0] = r_q.link;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic eng_busy,
    input logic eng_done,
    input logic go_q
);
    // R3: clock parked low between frames
    a_r3_mdc_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);

    // R1: line released between frames
    a_r1_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdio_oe);

    // R6: data out never moves with a rising MDC edge
    a_r6_mdio_holds_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o));

    // R7: a frame only runs while the start bit is set
    a_r7_busy_implies_go: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> go_q);

    // R7: start bit self-clears once the frame ends
    a_r7_go_clears_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !go_q);
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .eng_busy(eng_busy),
    .eng_done(eng_done),
    .go_q    (go_q)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    // PHY model state
    int          rise_idx = 0;
    logic [63:0] cap_o, cap_oe;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_data = '0;
    longint      t_r1, t_r2;

    // {wr, ack, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 5'd3,  5'd0,  16'hA5C3},
        {1'b0, 1'b1, 5'd7,  5'd2,  16'h1234},
        {1'b0, 1'b1, 5'd31, 5'd31, 16'hFFFE},
        {1'b0, 1'b0, 5'd0,  5'd4,  16'h5555},
        {1'b1, 1'b0, 5'd31, 5'd31, 16'h0000},
        {1'b0, 1'b1, 5'd5,  5'd1,  16'h0004},
        {1'b0, 1'b1, 5'd9,  5'd2,  16'h0004},
        {1'b0, 1'b0, 5'd9,  5'd1,  16'h0004},
        {1'b0, 1'b1, 5'd5,  5'd1,  16'hFFFB}
    };

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge mdc) begin
        if (rise_idx < 64) begin
            cap_o[63-rise_idx]  = mdio_o;
            cap_oe[63-rise_idx] = mdio_oe;
        end
        if (rise_idx == 1) t_r1 = $time;
        if (rise_idx == 2) t_r2 = $time;
        rise_idx = rise_idx + 1;
    end

    always @(negedge mdc) begin
        if (rise_idx == 47)
            mdio_i = !phy_ack;
        else if (rise_idx >= 48 && rise_idx <= 63)
            mdio_i = phy_ack ? phy_data[63-rise_idx] : 1'b1;
        else
            mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        reg_read(2'd1, v);
        while (v[31] && n < 50000) begin
            @(negedge clk);
            reg_read(2'd1, v);
            n++;
        end
        chk(req, {63'd0, v[31]}, 64'd0);
    endtask

    function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, p, r,
                w ? 2'b10 : 2'b00, w ? d : 16'h0000};
    endfunction

    function automatic logic [63:0] exp_oe(input logic w);
        return w ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
    endfunction

    task automatic start_frame(input logic w, input logic [4:0] p, input logic [4:0] r,
                               input logic [15:0] d);
        rise_idx = 0;
        cap_o = '0;
        cap_oe = '0;
        reg_write(2'd1, {1'b1, w, 1'b0, 3'b000, r, p, d});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] exp_link;
        exp_link = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        reg_read(2'd0, v); chk("R1 ctrl", {32'd0, v}, 64'h8000_0000);
        reg_read(2'd1, v); chk("R1 cmd", {32'd0, v}, 64'd0);
        reg_read(2'd2, v); chk("R1 link", {32'd0, v}, 64'd0);
        chk("R1 pins", {62'd0, mdc, mdio_oe}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: start ignored while disabled
        reg_write(2'd0, 32'h0000_0002);
        rise_idx = 0;
        reg_write(2'd1, 32'h8000_0000);
        repeat (40) @(negedge clk);
        reg_read(2'd1, v); chk("R11 go stays clear", {63'd0, v[31]}, 64'd0);
        reg_read(2'd0, v); chk("R11 idle", {63'd0, v[31]}, 64'd1);
        chk("R11 no mdc", 64'(rise_idx), 64'd0);

        // R2: control readback
        reg_write(2'd0, 32'h4000_0001);
        reg_read(2'd0, v); chk("R2 ctrl readback", {32'd0, v}, 64'hC000_0001);

        // Vector table (R4 R5 R7 R8 R10)
        for (int i = 0; i < NVEC; i++) begin
            logic        w, a;
            logic [4:0]  p, r;
            logic [15:0] d, ed;
            {w, a, p, r, d} = VEC[i];
            phy_ack  = a && !w;
            phy_data = d;
            start_frame(w, p, r, d);
            wait_idle("R7 go self-clears");
            chk(w ? "R4 write bits" : "R5 read bits", cap_o & exp_oe(w),
                exp_frame(w, p, r, d) & exp_oe(w));
            chk(w ? "R4 write oe" : "R5 read oe", cap_oe, exp_oe(w));
            chk("R7 64 rises", 64'(rise_idx), 64'd64);
            ed = w ? d : (a ? d : 16'hFFFF);
            reg_read(2'd1, v);
            chk("R8 result word", {32'd0, v},
                {32'd0, 1'b0, w, (a && !w), 3'b000, r, p, ed});
            if (!w && a && r == 5'd1) exp_link[p] = d[2];
            reg_read(2'd2, v); chk("R10 link", {32'd0, v}, {32'd0, exp_link});
            chk("R3 mdc low after", {63'd0, mdc}, 64'd0);
        end

        // R2 idle low while pending, R3 period with divider 3
        reg_write(2'd0, 32'h4000_0003);
        phy_ack = 1'b1; phy_data = 16'hBEEF;
        start_frame(1'b0, 5'd2, 5'd3, 16'h0000);
        reg_read(2'd0, v); chk("R2 idle low while busy", {63'd0, v[31]}, 64'd0);
        // R9: command write while busy ignored
        repeat (20) @(negedge clk);
        reg_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b000, 5'd9, 5'd17, 16'h0000});
        wait_idle("R7 go self-clears");
        chk("R3 mdc period", 64'(t_r2 - t_r1), 64'(2 * 4 * CLK_PERIOD));
        chk("R9 frame unchanged", cap_o & exp_oe(1'b0),
            exp_frame(1'b0, 5'd2, 5'd3, 16'h0) & exp_oe(1'b0));
        reg_read(2'd1, v);
        chk("R9 fields unchanged", {32'd0, v},
            {32'd0, 1'b0, 1'b0, 1'b1, 3'b000, 5'd3, 5'd2, 16'hBEEF});
        reg_read(2'd0, v); chk("R2 idle after", {32'd0, v}, 64'hC000_0003);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule